// File: doc/BRIEF.md
# Reset Cause Flag Register

This block is a small bus-visible register that tells software why the chip last restarted. Four kinds of reset event feed it: power-on, the external reset pin, brown-out and the watchdog. Each event raises its own sticky flag. The flags stay set until software removes them by writing zeros. Software therefore reads the register early after boot and then clears it, so that the next restart leaves a clean record.

The power-on event is the only asynchronous input. It forces the register to a state with only the power-on flag set and all other flags cleared. The other three events are single-cycle synchronous pulses. These pulses never clear anything, because the register sits in a domain that only power-on resets. The power-on flag itself drops only when software writes a zero to it. Writing a one to any flag leaves that flag as it is, so software can clear flags one at a time. When an event and a clearing write hit the same flag in the same cycle, the event wins.

Top module: `rst_cause_reg`

## Requirements
- R1: `rd_data` always shows the flags combinationally. Bit 0 is the power-on flag. Bits 1, 2 and 3 are the external, brown-out and watchdog flags, which follow `evt_src` bits 0, 1 and 2. Bits 7 to 4 always read as zero.
- R2: While `por_evt` is high, and afterwards until a clock edge changes them, the flags read 4'b0001, so `rd_data` = 8'h01.
- R3: A one on `evt_src[k]` at a clock edge sets flag bit k+1 at that edge. It does not change any other flag.
- R4: Flags are sticky. With no write and no event, `rd_data` holds its value, and several flags can be set together.
- R5: At a clock edge with `wr_en` high, every flag whose `wr_data` bit is 0 is cleared. Every flag whose `wr_data` bit is 1 keeps its value.
- R6: The power-on flag (bit 0) is changed by no event on `evt_src`. After power-on it is cleared only by a write with `wr_data[0]` = 0.
- R7: If an event on `evt_src[k]` and a clearing write to bit k+1 occur at the same clock edge, the flag ends up set.
- R8: Writes to bits 7 to 4 have no effect, and those bits keep reading as zero.
- R9: A power-on event clears the external, brown-out and watchdog flags, whatever their previous values were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_evt | input | 1 | Power-on event. Asynchronous and active high. |
| evt_src | input | 3 | Synchronous reset-event pulses: bit 0 external, bit 1 brown-out, bit 2 watchdog |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data. A zero clears the flag at that position. |
| rd_data | output | 8 | Bus read data: flags in bits 3..0, zeros above |

## Verification
The hardest case to reach is a clash on the same bit: a pulse on one event input and a clearing write to that same flag at the same edge. The bench must also show that the power-on flag survives every other event and can be removed only by software. The stimulus builds up all flags, then clears them selectively with mixed-one/zero write patterns. After that it issues a watchdog pulse together with an all-zero write, and it raises power-on while an event pulse is active. A random phase then mixes events and writes, and a behavioural model is compared with the output on every cycle.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
   localparam int unsigned RSR_DATA_W_DFLT = 8;
   localparam int unsigned RSR_N_EVT_DFLT  = 3;
   localparam int unsigned RSR_PWR_BIT     = 0;
endpackage

// File: rtl/rsr_wr_decode.sv
module rsr_wr_decode #(
   parameter int unsigned FLAG_W = 4
) (
   input  logic              wr_en,
   input  logic [FLAG_W-1:0] wr_bits,
   output logic [FLAG_W-1:0] clr_vec
);
   always_comb begin
      for (int i = 0; i < FLAG_W; i++) begin
         clr_vec[i] = wr_en & ~wr_bits[i];
      end
   end
endmodule

// File: rtl/rsr_flag_cell.sv
module rsr_flag_cell #(
   parameter bit PWR_VAL = 1'b0
) (
   input  logic clk,
   input  logic por_evt,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or posedge por_evt) begin
      if (por_evt) begin
         flag_o <= PWR_VAL;
      end else if (set_i) begin
         flag_o <= 1'b1;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/rsr_readout.sv
module rsr_readout #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned FLAG_W = 4
) (
   input  logic [FLAG_W-1:0] flags,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (DATA_W > FLAG_W) begin : g_pad
         assign rd_data = {{(DATA_W-FLAG_W){1'b0}}, flags};
      end else begin : g_exact
         assign rd_data = flags;
      end
   endgenerate
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rsr_pkg::*;
#(
   parameter int unsigned DATA_W = RSR_DATA_W_DFLT,
   parameter int unsigned N_EVT  = RSR_N_EVT_DFLT
) (
   input  logic              clk,
   input  logic              por_evt,
   input  logic [N_EVT-1:0]  evt_src,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned FLAG_W = N_EVT + 1;

   generate
      if (N_EVT < 1) begin : g_bad_evt
         $error("rst_cause_reg: N_EVT must be at least 1");
      end
      if (DATA_W < FLAG_W) begin : g_bad_width
         $error("rst_cause_reg: DATA_W too narrow for the flags");
      end
   endgenerate

   logic [FLAG_W-1:0] clr_vec;
   logic [FLAG_W-1:0] set_vec;
   logic [FLAG_W-1:0] flags;

   generate
      if (DATA_W > FLAG_W) begin : g_rsvd
         logic unused_rsvd_wr;
         assign unused_rsvd_wr = ^wr_data[DATA_W-1:FLAG_W];
      end
   endgenerate

   rsr_wr_decode #(.FLAG_W(FLAG_W)) u_dec (
      .wr_en   (wr_en),
      .wr_bits (wr_data[FLAG_W-1:0]),
      .clr_vec (clr_vec)
   );

   assign set_vec = {evt_src, 1'b0};

   generate
      for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
         rsr_flag_cell #(.PWR_VAL(i == RSR_PWR_BIT)) u_cell (
            .clk     (clk),
            .por_evt (por_evt),
            .set_i   (set_vec[i]),
            .clr_i   (clr_vec[i]),
            .flag_o  (flags[i])
         );
      end
   endgenerate

   rsr_readout #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_rd (
      .flags   (flags),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned N_EVT  = 3
) (
   input logic              clk,
   input logic              por_evt,
   input logic [N_EVT-1:0]  evt_src,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data
);
   localparam int unsigned FLAG_W = N_EVT + 1;

   generate
      if (DATA_W > FLAG_W) begin : g_rsvd_chk
         AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (por_evt)
            rd_data[DATA_W-1:FLAG_W] == '0); // R8
      end
   endgenerate

   AST_PWR_HOLD: assert property (@(posedge clk) disable iff (por_evt)
      !(wr_en && !wr_data[0]) |=> $stable(rd_data[0])); // R6

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (por_evt)
      (!wr_en && evt_src == '0) |=> $stable(rd_data)); // R4

   AST_WR_CLEAR: assert property (@(posedge clk) disable iff (por_evt)
      (wr_en && !wr_data[1] && !evt_src[0]) |=> !rd_data[1]); // R5

   generate
      for (genvar k = 0; k < N_EVT; k++) begin : g_evt_chk
         AST_EVT_SET: assert property (@(posedge clk) disable iff (por_evt)
            evt_src[k] |=> rd_data[k+1]); // R3
         AST_SET_WINS: assert property (@(posedge clk) disable iff (por_evt)
            (evt_src[k] && wr_en && !wr_data[k+1]) |=> rd_data[k+1]); // R7
      end
   endgenerate
endmodule

bind rst_cause_reg rst_cause_reg_chk #(.DATA_W(DATA_W), .N_EVT(N_EVT)) u_chk (
   .clk     (clk),
   .por_evt (por_evt),
   .evt_src (evt_src),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data)
);

// File: tb/rst_cause_reg_test.sv
`timescale 1ns/1ps
module rst_cause_reg_test;
   logic       clk = 1'b0;
   logic       por = 1'b1;
   logic [2:0] evt = '0;
   logic       we  = 1'b0;
   logic [7:0] wd  = '0;
   logic [7:0] rd;
   int total = 0;
   int bad = 0;
   int cycles = 0;
   int model = 1;
   string tag = "R2";
   bit done = 1'b0;

   always #4 clk = ~clk;

   rst_cause_reg uut (
      .clk(clk), .por_evt(por), .evt_src(evt),
      .wr_en(we), .wr_data(wd), .rd_data(rd)
   );

   // behavioural reference: flags as an integer, updated per clock
   always @(posedge clk or posedge por) begin
      if (por) begin
         model <= 1;
      end else begin
         int nxt;
         nxt = model;
         if (we) nxt = nxt & (wd & 15);
         for (int k = 0; k < 3; k++) if (evt[k]) nxt = nxt | (2 << k);
         model <= nxt;
      end
   end

   task automatic check(input logic [7:0] exp, input string t);
      total++;
      if (rd !== exp) begin
         bad++;
         $display("FAIL %s: rd_data=%h expected=%h", t, rd, exp);
      end
   endtask

   // compare with model at negedge, then drive the next stimulus
   task automatic step(input logic p, input logic [2:0] e, input logic w,
                       input logic [7:0] d, input string t);
      @(negedge clk);
      check(8'(model), tag);
      por = p; evt = e; we = w; wd = d; tag = t;
   endtask

   task automatic idle_expect(input logic [7:0] exp, input string t);
      step(1'b0, 3'b000, 1'b0, 8'h00, t);
      @(negedge clk);
      check(exp, t);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         bad++; total++;
         $display("FAIL watchdog: cycles=%0d expected=<20000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      check(8'h01, "R2 reset state");
      step(1'b0, 3'b000, 1'b0, 8'h00, "R2");
      idle_expect(8'h01, "R2 after release");
      step(1'b0, 3'b001, 1'b0, 8'h00, "R3 ext");
      idle_expect(8'h03, "R3 ext sets bit1");
      step(1'b0, 3'b010, 1'b0, 8'h00, "R3 brown");
      idle_expect(8'h07, "R4 brown accumulates");
      step(1'b0, 3'b100, 1'b0, 8'h00, "R3 wdog");
      idle_expect(8'h0F, "R4 all flags set");
      step(1'b0, 3'b000, 1'b1, 8'hFF, "R5 write ones");
      idle_expect(8'h0F, "R5 ones keep flags");
      step(1'b0, 3'b000, 1'b1, 8'hF0, "R8 write upper ones");
      idle_expect(8'h00, "R8 upper ignored, R6 bit0 cleared by write");
      step(1'b0, 3'b100, 1'b0, 8'h00, "R6 wdog with bit0 clear");
      idle_expect(8'h08, "R6 event leaves bit0 clear");
      step(1'b1, 3'b000, 1'b0, 8'h00, "R9 power-on");
      step(1'b0, 3'b000, 1'b0, 8'h00, "R9");
      idle_expect(8'h01, "R9 power-on clears event flags");
      step(1'b0, 3'b111, 1'b0, 8'h00, "R4 all events");
      idle_expect(8'h0F, "R4 multiple events at once");
      step(1'b0, 3'b000, 1'b1, 8'hFA, "R5 selective");
      idle_expect(8'h0A, "R5 selective clear of bits 2 and 0");
      step(1'b0, 3'b100, 1'b1, 8'h00, "R7 clash");
      idle_expect(8'h08, "R7 set wins over clear");
      step(1'b1, 3'b010, 1'b0, 8'h00, "R9 power-on with event");
      step(1'b0, 3'b000, 1'b0, 8'h00, "R2");
      idle_expect(8'h01, "R2 power-on dominates event");
      step(1'b0, 3'b100, 1'b1, 8'hFF, "R6 wdog while bit0 set");
      idle_expect(8'h09, "R6 bit0 kept by events");
      idle_expect(8'h09, "R1 layout read");
      for (int i = 0; i < 400; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         step(($urandom % 50) == 0, 3'($urandom) & 3'($urandom),
              ($urandom % 3) == 0, d, "R4 random");
      end
      step(1'b0, 3'b000, 1'b0, 8'h00, "R4 end");
      @(negedge clk);
      check(8'(model), "R1 final");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule